// File: doc/BRIEF.md
# Burst-of-Two Double-Rate Memory Datapath

This block is a synthesizable behavioural memory with a shared data path that moves two beats per access. Each clock of `clk` is one beat, which stands in for one edge of a double-rate interface. Two beats form one command cycle. A write delivers a low half-word and then a high half-word. The two halves are joined and stored as one double-width word in a single array update. A read fetches one double-width word and returns it as two consecutive beats, low half first. The address therefore selects double-width words, and a one-bit-narrower address covers the same capacity as a single-width organisation.

Every stored word is protected by a Hamming code with one extra overall-parity bit. For the defaults that is 36 data bits and 7 check bits. A single flipped bit anywhere in a stored word is corrected on the way out, and a flag marks the returned beats. A write can deliberately flip one stored bit so that the correction path can be exercised. Read latency is selectable as two or three command cycles. A pending-write register and an index comparator keep reads coherent with writes that have not yet reached the array.

The command and data path has no ready signal: the block takes one command every cycle and never stalls. Read data leaves under `rvalid`, and the consumer must accept it in the beat it is shown. The read path has no back-pressure.

Top module: `dual_beat_mem`

## Requirements
- R1: While `rst_n` is low, and after it rises until a read has completed, `rdata_oe`, `rvalid` and `ecc_fix` are low.
- R2: The first rising edge of `clk` after reset release is a cycle-start edge, and cycle starts then fall on every second edge. `cmd_ld`, `cmd_rw` (1 = read, 0 = write), `cmd_addr`, `inj_en` and `inj_bit` are sampled only on cycle-start edges. Values on the other edges have no effect.
- R3: For a write, `wdata` at the cycle-start edge becomes bits [BEAT_W-1:0] of the stored word. `wdata` at the following edge becomes bits [2*BEAT_W-1:BEAT_W].
- R4: A read returns bits [BEAT_W-1:0] on `rdata` in the first beat and the upper half in the next beat. `rdata_oe` and `rvalid` are high for exactly those two beats. Reads issued in consecutive cycles give an unbroken stream.
- R5: With `lat_sel`=0 the first beat appears after the edge 4 edges (2 cycles) after the read's cycle-start edge. With `lat_sel`=1 it appears after the edge 6 edges (3 cycles) later.
- R6: A read returns the most recent write to its index, including a write issued in the cycle just before the read.
- R7: A write with `inj_en`=1 stores its codeword with bit `inj_bit` inverted. Valid positions are 0 to 42 for the defaults, and position 0 is the overall-parity bit. A later read still returns the written data.
- R8: `ecc_fix` is high during both beats of a read whose stored word needed a single-bit correction, and is low otherwise.
- R9: A cycle with `cmd_ld` low changes no stored word, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; two edges per command cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_sel | input | 1 | Read latency: 0 = 2 cycles, 1 = 3 cycles |
| cmd_ld | input | 1 | Command strobe, sampled on cycle-start edges |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Index of the double-width word |
| wdata | input | BEAT_W | Write beat, low half then high half |
| inj_en | input | 1 | Flip one stored bit for this write |
| inj_bit | input | IDX_W | Codeword bit position to flip |
| rdata | output | BEAT_W | Read beat |
| rdata_oe | output | 1 | Bus drive enable for read beats |
| rvalid | output | 1 | High during the two read beats |
| ecc_fix | output | 1 | Read word was corrected |

## Verification
The assertions take three things for granted. `lat_sel` only changes while no read is in flight. `inj_bit` names an existing codeword position whenever a write injects a flip. Reads are only aimed at indices already written, because the array has no reset. The stimulus changes `lat_sel` only after several idle cycles have drained the read pipeline. It draws injection positions from 0 to 42. Any random read to an index that has never been written is turned into a write. The random stream also drives garbage on the odd edges and in idle cycles, so that the ignored inputs are exercised.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_e;

  // smallest number of Hamming check bits covering dw data bits
  function automatic int hamming_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < (dw + p + 1)) p++;
    return p;
  endfunction

  function automatic logic is_pow2(input int v);
    return ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/dbm_ecc_enc.sv
module dbm_ecc_enc
  import dbm_pkg::*;
#(
  parameter  int DATA_W = 36,
  parameter  int CHK_W  = 6,
  localparam int CW_W   = DATA_W + CHK_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   code
);

  // bit 0: overall parity; power-of-two positions: check bits; rest: data
  always_comb begin
    int j;
    logic par;
    code = '0;
    j = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        code[p] = data[j];
        j++;
      end
    end
    for (int k = 0; k < CHK_W; k++) begin
      par = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> k) & 1) == 1) par = par ^ code[p];
      end
      code[1 << k] = par;
    end
    code[0] = ^code[CW_W-1:1];
  end

endmodule

// File: rtl/dbm_ecc_dec.sv
module dbm_ecc_dec
  import dbm_pkg::*;
#(
  parameter  int DATA_W = 36,
  parameter  int CHK_W  = 6,
  localparam int CW_W   = DATA_W + CHK_W + 1
) (
  input  logic [CW_W-1:0]   code,
  output logic [DATA_W-1:0] data,
  output logic              fixed
);

  always_comb begin
    logic [CHK_W-1:0] syn;
    logic [CW_W-1:0]  c;
    int j;
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (code[p]) syn = syn ^ CHK_W'(p);
    end
    // odd overall parity means exactly one flipped bit (syndrome 0: parity bit)
    fixed = ^code;
    c = code;
    if (fixed && (syn != '0) && (int'(syn) < CW_W)) c[syn] = ~c[syn];
    data = '0;
    j = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        data[j] = c[p];
        j++;
      end
    end
  end

endmodule

// File: rtl/dbm_rd_align.sv
module dbm_rd_align #(
  parameter  int BEAT_W  = 18,
  parameter  int MIN_LAT = 2,
  parameter  int MAX_LAT = 3,
  localparam int WORD_W  = 2 * BEAT_W,
  localparam int NSTG    = MAX_LAT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph,
  input  logic              lat_sel,
  input  logic              in_v,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_fix,
  output logic [BEAT_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              rvalid,
  output logic              ecc_fix
);

  logic              s_v [1:NSTG];
  logic [WORD_W-1:0] s_w [1:NSTG];
  logic              s_f [1:NSTG];

  // delay line advancing once per command cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= NSTG; i++) begin
        s_v[i] <= 1'b0;
        s_w[i] <= '0;
        s_f[i] <= 1'b0;
      end
    end else if (!ph) begin
      s_v[1] <= in_v;
      s_w[1] <= in_word;
      s_f[1] <= in_fix;
      for (int i = 2; i <= NSTG; i++) begin
        s_v[i] <= s_v[i-1];
        s_w[i] <= s_w[i-1];
        s_f[i] <= s_f[i-1];
      end
    end
  end

  int                sel;
  logic              pick_v;
  logic              pick_f;
  logic [WORD_W-1:0] pick_w;

  always_comb begin
    sel    = lat_sel ? (MAX_LAT - 1) : (MIN_LAT - 1);
    pick_v = s_v[sel];
    pick_f = s_f[sel];
    pick_w = s_w[sel];
  end

  logic              o_v;
  logic              o_f;
  logic [BEAT_W-1:0] o_d;
  logic [BEAT_W-1:0] o_hi;

  // low half on the cycle-start edge, high half on the next edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_v  <= 1'b0;
      o_f  <= 1'b0;
      o_d  <= '0;
      o_hi <= '0;
    end else if (!ph) begin
      o_v <= pick_v;
      o_f <= pick_v & pick_f;
      if (pick_v) begin
        o_d  <= pick_w[BEAT_W-1:0];
        o_hi <= pick_w[WORD_W-1:BEAT_W];
      end
    end else if (o_v) begin
      o_d <= o_hi;
    end
  end

  assign rdata    = o_d;
  assign rdata_oe = o_v;
  assign rvalid   = o_v;
  assign ecc_fix  = o_f;

endmodule

// File: rtl/dual_beat_mem.sv
module dual_beat_mem
  import dbm_pkg::*;
#(
  parameter  int BEAT_W = 18,
  parameter  int ADDR_W = 8,
  localparam int WORD_W = 2 * BEAT_W,
  localparam int CHK_W  = hamming_bits(WORD_W),
  localparam int CW_W   = WORD_W + CHK_W + 1,
  localparam int IDX_W  = $clog2(CW_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_sel,
  input  logic              cmd_ld,
  input  logic              cmd_rw,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BEAT_W-1:0] wdata,
  input  logic              inj_en,
  input  logic [IDX_W-1:0]  inj_bit,
  output logic [BEAT_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              rvalid,
  output logic              ecc_fix
);

  localparam int DEPTH = 1 << ADDR_W;

  // ph = 0: the coming edge starts a command cycle
  logic ph;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  logic [CW_W-1:0] inj_mask;
  always_comb begin
    inj_mask = '0;
    if (inj_en) inj_mask[inj_bit] = 1'b1;
  end

  // command stage, loaded on cycle-start edges together with the low beat
  logic              a_v;
  logic              a_rd;
  logic [ADDR_W-1:0] a_addr;
  logic [CW_W-1:0]   a_mask;
  logic [BEAT_W-1:0] a_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_v    <= 1'b0;
      a_rd   <= 1'b0;
      a_addr <= '0;
      a_mask <= '0;
      a_lo   <= '0;
    end else if (!ph) begin
      a_v    <= cmd_ld;
      a_rd   <= (cmd_rw == CMD_READ);
      a_addr <= cmd_addr;
      a_mask <= inj_mask;
      a_lo   <= wdata;
    end
  end

  logic [CW_W-1:0] enc_code;

  dbm_ecc_enc #(.DATA_W(WORD_W), .CHK_W(CHK_W)) u_enc (
    .data ({wdata, a_lo}),
    .code (enc_code)
  );

  logic [CW_W-1:0] mem [DEPTH];

  logic              p_v;
  logic [ADDR_W-1:0] p_addr;
  logic [CW_W-1:0]   p_code;
  logic              r_v;
  logic [CW_W-1:0]   r_code;
  logic              wr_go;
  logic              rd_go;
  logic              hit;

  assign wr_go = a_v && !a_rd;
  assign rd_go = a_v &&  a_rd;
  assign hit   = p_v && (p_addr == a_addr);

  // second edge: park the joined word, fetch a read with forwarding
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_v    <= 1'b0;
      p_addr <= '0;
      p_code <= '0;
      r_v    <= 1'b0;
      r_code <= '0;
    end else if (ph) begin
      p_v <= wr_go;
      if (wr_go) begin
        p_addr <= a_addr;
        p_code <= enc_code ^ a_mask;
      end
      r_v <= rd_go;
      if (rd_go) r_code <= hit ? p_code : mem[a_addr];
    end
  end

  // parked word reaches the array one cycle later
  always_ff @(posedge clk) begin
    if (ph && p_v) mem[p_addr] <= p_code;
  end

  logic [WORD_W-1:0] dec_data;
  logic              dec_fix;

  dbm_ecc_dec #(.DATA_W(WORD_W), .CHK_W(CHK_W)) u_dec (
    .code  (r_code),
    .data  (dec_data),
    .fixed (dec_fix)
  );

  dbm_rd_align #(.BEAT_W(BEAT_W), .MIN_LAT(2), .MAX_LAT(3)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .lat_sel  (lat_sel),
    .in_v     (r_v),
    .in_word  (dec_data),
    .in_fix   (dec_fix),
    .rdata    (rdata),
    .rdata_oe (rdata_oe),
    .rvalid   (rvalid),
    .ecc_fix  (ecc_fix)
  );

endmodule

// File: rtl/dual_beat_mem_chk.sv
module dual_beat_mem_chk #(
  parameter int IDX_W = 6,
  parameter int CW_W  = 43
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ph,
  input logic             lat_sel,
  input logic             cmd_ld,
  input logic             cmd_rw,
  input logic             inj_en,
  input logic [IDX_W-1:0] inj_bit,
  input logic             rdata_oe,
  input logic             rvalid,
  input logic             ecc_fix
);

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!rdata_oe && !rvalid && !ecc_fix));

  a_r5_lat_two: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ld && cmd_rw && !ph && !lat_sel) |-> ##5 rvalid ##1 rvalid);

  a_r5_lat_three: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ld && cmd_rw && !ph && lat_sel) |-> ##7 rvalid ##1 rvalid);

  a_r4_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid);

  a_r4_cycle_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> ph);

  a_r8_fix_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_fix |-> rvalid);

  a_r7_inject_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en && cmd_ld && !cmd_rw && !ph) |-> (int'(inj_bit) < CW_W));

endmodule

bind dual_beat_mem dual_beat_mem_chk #(.IDX_W(IDX_W), .CW_W(CW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ph       (ph),
  .lat_sel  (lat_sel),
  .cmd_ld   (cmd_ld),
  .cmd_rw   (cmd_rw),
  .inj_en   (inj_en),
  .inj_bit  (inj_bit),
  .rdata_oe (rdata_oe),
  .rvalid   (rvalid),
  .ecc_fix  (ecc_fix)
);

// File: tb/dual_beat_mem_tb.sv
module dual_beat_mem_tb;

  localparam int BW = 18;
  localparam int AW = 8;

  // 20-unit period: 50 MHz with a 1 ns unit
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, lat_sel, cmd_ld, cmd_rw, inj_en;
  logic [AW-1:0] cmd_addr;
  logic [BW-1:0] wdata;
  logic [5:0]    inj_bit;
  logic [BW-1:0] rdata;
  logic          rdata_oe, rvalid, ecc_fix;

  dual_beat_mem #(.BEAT_W(BW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .cmd_ld(cmd_ld),
    .cmd_rw(cmd_rw), .cmd_addr(cmd_addr), .wdata(wdata), .inj_en(inj_en),
    .inj_bit(inj_bit), .rdata(rdata), .rdata_oe(rdata_oe),
    .rvalid(rvalid), .ecc_fix(ecc_fix)
  );

  int n_chk = 0;
  int n_err = 0;
  int k = 0;
  bit done = 1'b0;

  logic          ev [64];
  logic [BW-1:0] ed [64];
  logic          ef [64];
  string         et [64];

  logic [2*BW-1:0] rmem [256];
  logic            rinj [256];
  logic            rok  [256];
  logic            last_w;
  logic [AW-1:0]   last_wa;

  function automatic int rn(input int n);
    return int'($urandom % n);
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_out();
    int idx;
    idx = k % 64;
    if (ev[idx]) begin
      chk(rdata_oe === 1'b1 && rvalid === 1'b1, "R5", "read beat strobes",
          64'({rdata_oe, rvalid}), 64'(3));
      chk(rdata === ed[idx], et[idx], "read beat data", 64'(rdata), 64'(ed[idx]));
      chk(ecc_fix === ef[idx], "R8", "correction flag", 64'(ecc_fix), 64'(ef[idx]));
      ev[idx] = 1'b0;
    end else begin
      chk(rdata_oe === 1'b0 && rvalid === 1'b0 && ecc_fix === 1'b0, "R4",
          "no read due", 64'({rdata_oe, rvalid, ecc_fix}), 64'(0));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_out();
    k++;
  endtask

  // one command cycle; odd edge carries garbage controls (R2)
  task automatic cyc(input logic l, input logic r, input logic [AW-1:0] a,
                     input logic [BW-1:0] d0, input logic [BW-1:0] d1,
                     input logic ie, input logic [5:0] ip);
    int lb;
    int i0;
    string tg;
    cmd_ld = l; cmd_rw = r; cmd_addr = a; wdata = d0;
    inj_en = ie; inj_bit = ip;
    if (l && r) begin
      lb = lat_sel ? 6 : 4;
      i0 = (k + lb) % 64;
      if (rinj[a])                   tg = "R7";
      else if (last_w && last_wa == a) tg = "R6";
      else                           tg = "R3 R9";
      ev[i0] = 1'b1; ed[i0] = rmem[a][BW-1:0];    ef[i0] = rinj[a]; et[i0] = tg;
      i0 = (i0 + 1) % 64;
      ev[i0] = 1'b1; ed[i0] = rmem[a][2*BW-1:BW]; ef[i0] = rinj[a]; et[i0] = tg;
    end
    if (l && !r) begin
      rmem[a] = {d1, d0};  // R3: first beat is the low half
      rinj[a] = ie;
      rok[a]  = 1'b1;
    end
    last_w  = l && !r;
    last_wa = a;
    step();
    cmd_ld = 1'(rn(2)); cmd_rw = 1'(rn(2)); cmd_addr = AW'(rn(256));
    inj_en = 1'(rn(2)); inj_bit = 6'(rn(64)); wdata = d1;
    step();
  endtask

  // R9: idle cycles with random payload must leave storage alone
  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cyc(1'b0, 1'(rn(2)), AW'(rn(256)), BW'(rn(1 << BW)), BW'(rn(1 << BW)),
          1'(rn(2)), 6'(rn(43)));
  endtask

  task automatic wr(input int a, input int d0, input int d1,
                    input logic ie, input int ip);
    cyc(1'b1, 1'b0, AW'(a), BW'(d0), BW'(d1), ie, 6'(ip));
  endtask

  task automatic rd(input int a);
    cyc(1'b1, 1'b1, AW'(a), BW'(rn(1 << BW)), BW'(rn(1 << BW)), 1'b0, 6'(0));
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      int c;
      int a;
      c = rn(4);
      a = rn(8);
      if (c == 0) idle(1);
      else if (c == 1 || !rok[a])
        wr(a, rn(1 << BW), rn(1 << BW), (rn(8) == 0), rn(43));
      else rd(a);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      ev[i] = 1'b0; ed[i] = '0; ef[i] = 1'b0; et[i] = "";
    end
    for (int i = 0; i < 256; i++) begin
      rmem[i] = '0; rinj[i] = 1'b0; rok[i] = 1'b0;
    end
    last_w = 1'b0; last_wa = '0;
    rst_n = 1'b0; lat_sel = 1'b0; cmd_ld = 1'b0; cmd_rw = 1'b0;
    cmd_addr = '0; wdata = '0; inj_en = 1'b0; inj_bit = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet outputs in reset
    chk(rdata_oe === 1'b0, "R1", "rdata_oe in reset", 64'(rdata_oe), 64'(0));
    chk(rvalid === 1'b0,   "R1", "rvalid in reset",   64'(rvalid),   64'(0));
    chk(ecc_fix === 1'b0,  "R1", "ecc_fix in reset",  64'(ecc_fix),  64'(0));
    rst_n = 1'b1;

    // two-cycle latency, directed corners
    wr(5, 'h11111, 'h22222, 1'b0, 0);
    rd(5);                                 // R6: forwarded from the parked write
    idle(3);
    rd(5);                                 // R3: from the array
    wr(6, 'h0AAAA, 'h15555, 1'b0, 0);
    wr(6, 'h3C3C3, 'h03C3C, 1'b0, 0);
    rd(6);                                 // R6: newest of two writes
    wr(7, 'h12345, 'h2ABCD, 1'b1, 0);      // R7: overall parity bit
    wr(8, 'h00001, 'h3FFFF, 1'b1, 1);      // R7: a check bit
    wr(9, 'h2F0F0, 'h10F0F, 1'b1, 5);      // R7: a data bit
    wr(10, 'h3FFFF, 'h00000, 1'b1, 42);    // R7: top position
    rd(10);                                // R7 with forwarding
    rd(7); rd(8); rd(9);                   // R4: unbroken stream
    idle(4);
    rand_run(1500);
    idle(5);

    // three-cycle latency
    lat_sel = 1'b1;
    idle(2);
    wr(3, 'h1E1E1, 'h2D2D2, 1'b0, 0);
    rd(3);                                 // R5 and R6
    rd(7);
    idle(4);
    rand_run(1500);
    idle(6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", k, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule